// File: doc/BRIEF.md
# Iterative 64-bit Integer Multiply Unit

This unit produces the multiply results of the RISC-V M extension for a 64-bit core. A request carries two 64-bit register operands, the 3-bit minor opcode (funct3) and a flag that marks the 32-bit word opcode group. The unit decodes these into one of five forms. The full-width forms are the low half of the product, or the high half with both operands signed, first signed and second unsigned, or both unsigned. The word form multiplies the low 32 bits of each operand and sign-extends the low 32 bits of that product. Encodings that are not multiplies are flagged illegal and return no result.

The datapath is a radix-2 shift-add loop with an adder one bit wider than an operand. It handles one request at a time. Signed operands are turned into magnitudes before the loop starts, and the product is negated at the end when exactly one operand was negative. A full-width operation takes XLEN iterations. A word operation takes XLEN/2 iterations.

Both data interfaces use valid/ready. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so a request offered while an operation is in flight or a result is waiting is neither taken nor stored. A result stays presented, unchanged, until the edge where `out_valid` and `out_ready` are both high. The unit is ready for a new request in the cycle after that edge.

Top module: `imul_unit`

## Requirements
- R1: With word=0 and funct3=000, the result is bits XLEN-1:0 of the product of the two operands.
- R2: With word=0 and funct3=001, the result is bits 2*XLEN-1:XLEN of the product, with both operands read as two's-complement signed.
- R3: With word=0 and funct3=010, the result is the upper half of the product of signed `in_a` and unsigned `in_b`.
- R4: With word=0 and funct3=011, the result is the upper half of the product with both operands read as unsigned.
- R5: With word=1 and funct3=000, the result is the low XLEN/2 bits of the product of the low XLEN/2 bits of each operand, sign-extended from bit XLEN/2-1 to XLEN bits.
- R6: Word=1 with any funct3 other than 000, and word=0 with funct3[2]=1, give `out_illegal`=1 with `out_result`=0. Legal forms give `out_illegal`=0.
- R7: Counting clock edges after the accepting edge, `out_valid` rises on edge XLEN for full-width forms, on edge XLEN/2 for the word form, and on the accepting edge itself for illegal requests.
- R8: `in_ready` is low from the accepting edge until the result has been taken. `in_valid` asserted during that time has no effect on the pending result.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_result` and `out_illegal` hold. After the edge where the result is taken, `out_valid`=0 and `in_ready`=1.
- R10: After reset, `in_ready`=1 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| in_funct3 | input | 3 | Minor opcode |
| in_word | input | 1 | Request comes from the 32-bit word opcode group |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Product result (0 when illegal) |
| out_illegal | output | 1 | Request was not a multiply encoding |

## Verification
The bench builds the unit with its default XLEN of 64. This exposes the two cases where the magnitude-and-negate scheme could go wrong: the most negative 64-bit value, whose magnitude needs the full unsigned width, and the 32-bit word path, whose product lands at a different position in the shift register. Random operands and opcodes are checked against 128-bit products computed in the bench. Directed operand pairs cover the extremes. The bench also holds back `out_ready` for random stretches and offers competing requests while the unit is busy.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [2:0] {
    MF_LOW  = 3'd0,
    MF_HSS  = 3'd1,
    MF_HSU  = 3'd2,
    MF_HUU  = 3'd3,
    MF_WORD = 3'd4,
    MF_BAD  = 3'd5
  } mform_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } mstate_e;
endpackage

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
(
  input  logic [2:0] funct3_i,
  input  logic       word_i,
  output mform_e     form_o
);
  always_comb begin
    form_o = MF_BAD;
    if (word_i) begin
      if (funct3_i == 3'b000) form_o = MF_WORD;
    end else begin
      case (funct3_i)
        3'b000:  form_o = MF_LOW;
        3'b001:  form_o = MF_HSS;
        3'b010:  form_o = MF_HSU;
        3'b011:  form_o = MF_HUU;
        default: form_o = MF_BAD;
      endcase
    end
  end
endmodule

// File: rtl/imul_prep.sv
module imul_prep
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  mform_e          form_i,
  output logic [XLEN-1:0] mcand_o,
  output logic [XLEN-1:0] mplier_o,
  output logic [CW-1:0]   steps_o,
  output logic            neg_o
);
  localparam int HALF = XLEN / 2;

  logic sa, sb, na, nb;

  always_comb begin
    sa = (form_i == MF_HSS) || (form_i == MF_HSU);
    sb = (form_i == MF_HSS);
    na = sa && a_i[XLEN-1];
    nb = sb && b_i[XLEN-1];
    neg_o    = na ^ nb;
    mcand_o  = na ? (~a_i + 1'b1) : a_i;
    mplier_o = nb ? (~b_i + 1'b1) : b_i;
    steps_o  = CW'(XLEN);
    if (form_i == MF_WORD) begin
      mcand_o  = {{(XLEN-HALF){1'b0}}, a_i[HALF-1:0]};
      mplier_o = {{(XLEN-HALF){1'b0}}, b_i[HALF-1:0]};
      steps_o  = CW'(HALF);
    end else if (form_i == MF_BAD) begin
      mcand_o  = '0;
      mplier_o = '0;
      steps_o  = '0;
    end
  end
endmodule

// File: rtl/imul_iter.sv
module imul_iter #(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  input  logic [CW-1:0]     steps_i,
  output logic [2*XLEN-1:0] prod_o,
  output logic              last_o
);
  logic [XLEN-1:0] hi_q, lo_q, mc_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   sum;

  always_comb begin
    sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      mc_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      hi_q  <= '0;
      lo_q  <= mplier_i;
      mc_q  <= mcand_i;
      cnt_q <= steps_i;
    end else if (cnt_q != '0) begin
      hi_q  <= sum[XLEN:1];
      lo_q  <= {sum[0], lo_q[XLEN-1:1]};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign prod_o = {hi_q, lo_q};
  assign last_o = (cnt_q == CW'(1));

  // R7
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [2:0]      in_funct3,
  input  logic            in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  localparam int CW   = $clog2(XLEN + 1);
  localparam int HALF = XLEN / 2;

  mform_e            dec_form, form_q;
  mstate_e           state_q;
  logic [XLEN-1:0]   mcand, mplier;
  logic [CW-1:0]     steps;
  logic              neg, neg_q, last, take;
  logic [2*XLEN-1:0] prod, sprod;

  imul_decode u_dec (
    .funct3_i(in_funct3), .word_i(in_word), .form_o(dec_form)
  );

  imul_prep #(.XLEN(XLEN), .CW(CW)) u_prep (
    .a_i(in_a), .b_i(in_b), .form_i(dec_form),
    .mcand_o(mcand), .mplier_o(mplier), .steps_o(steps), .neg_o(neg)
  );

  assign in_ready = (state_q == ST_IDLE);
  assign take     = in_valid && in_ready;

  imul_iter #(.XLEN(XLEN), .CW(CW)) u_iter (
    .clk(clk), .rst_n(rst_n), .load_i(take && dec_form != MF_BAD),
    .mcand_i(mcand), .mplier_i(mplier), .steps_i(steps),
    .prod_o(prod), .last_o(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      form_q  <= MF_BAD;
      neg_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          form_q  <= dec_form;
          neg_q   <= neg;
          state_q <= (dec_form == MF_BAD) ? ST_HOLD : ST_RUN;
        end
        ST_RUN:  if (last) state_q <= ST_HOLD;
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sprod = neg_q ? (~prod + 1'b1) : prod;
    case (form_q)
      MF_LOW:  out_result = sprod[XLEN-1:0];
      MF_HSS, MF_HSU, MF_HUU: out_result = sprod[2*XLEN-1:XLEN];
      MF_WORD: out_result = {{(XLEN-HALF){prod[XLEN-1]}}, prod[XLEN-1:HALF]};
      default: out_result = '0;
    endcase
  end

  assign out_valid   = (state_q == ST_HOLD);
  assign out_illegal = (form_q == MF_BAD);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R8
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  // R5
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && form_q == MF_WORD) |->
      (out_result[XLEN-1:HALF-1] == '0 || out_result[XLEN-1:HALF-1] == '1));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: tb/imul_unit_tb.sv
`timescale 1ns/1ps
module imul_unit_tb_top;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_word = 1'b0, out_ready = 1'b0;
  logic [XLEN-1:0] in_a = '0, in_b = '0;
  logic [2:0] in_funct3 = '0;
  logic in_ready, out_valid, out_illegal;
  logic [XLEN-1:0] out_result;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  imul_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_funct3(in_funct3), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(bit ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [2:0] f3, logic w);
    logic [127:0] ea, eb, p;
    logic [63:0] m;
    if (w) begin
      if (f3 != 3'b000) return {1'b1, 64'd0};
      m = {32'd0, a[31:0]} * {32'd0, b[31:0]};
      return {1'b0, {32{m[31]}}, m[31:0]};
    end
    if (f3[2]) return {1'b1, 64'd0};
    ea = (f3 == 3'b001 || f3 == 3'b010) ? {{64{a[63]}}, a} : {64'd0, a};
    eb = (f3 == 3'b001) ? {{64{b[63]}}, b} : {64'd0, b};
    p = ea * eb;
    return {1'b0, (f3 == 3'b000) ? p[63:0] : p[127:64]};
  endfunction

  function automatic string req_of(logic [2:0] f3, logic w);
    if (w) return (f3 == 3'b000) ? "R5" : "R6";
    case (f3)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic [2:0] f3, logic w,
                        int hold, bit intrude);
    logic [XLEN:0] exp;
    logic [XLEN-1:0] first;
    int lat, exp_lat;
    exp = model(a, b, f3, w);
    exp_lat = exp[XLEN] ? 0 : (w ? XLEN/2 : XLEN);
    @(negedge clk);
    in_a = a; in_b = b; in_funct3 = f3; in_word = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin
      in_a = ~a; in_b = b + 64'd3; in_funct3 = 3'b011; in_word = 1'b0;
    end else in_valid = 1'b0;
    lat = 0;
    // R8: busy means not ready
    check(in_ready == 1'b0, "R8", {63'd0, in_ready}, '0);
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    // R7
    check(lat == exp_lat, "R7", XLEN'(lat), XLEN'(exp_lat));
    check(out_result == exp[XLEN-1:0], req_of(f3, w), out_result, exp[XLEN-1:0]);
    // R6
    check(out_illegal == exp[XLEN], "R6", {63'd0, out_illegal}, {63'd0, exp[XLEN]});
    first = out_result;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      // R9
      check(out_valid && out_result == first && !in_ready, "R9", out_result, first);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    // R9: released
    check(!out_valid && in_ready, "R9", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] mn;
    mn = 64'h8000_0000_0000_0000;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R10
    check(in_ready == 1'b1, "R10", {63'd0, in_ready}, 64'd1);
    check(out_valid == 1'b0, "R10", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R10", {62'd0, in_ready, out_valid}, 64'd2);

    for (int f = 0; f < 4; f++) begin
      run_op(mn, mn, 3'(f), 1'b0, 0, 0);
      run_op(mn, '1, 3'(f), 1'b0, 0, 0);
      run_op('1, '1, 3'(f), 1'b0, 1, 0);
      run_op('1, mn, 3'(f), 1'b0, 0, 0);
      run_op(64'd0, '1, 3'(f), 1'b0, 0, 0);
      run_op(64'h7fff_ffff_ffff_ffff, 64'h7fff_ffff_ffff_ffff, 3'(f), 1'b0, 0, 0);
    end
    run_op(64'hdead_beef_8000_0000, 64'h1234_5678_8000_0000, 3'b000, 1'b1, 0, 0);
    run_op(64'h0000_0000_ffff_ffff, 64'hffff_ffff_0000_0002, 3'b000, 1'b1, 2, 0);
    run_op(64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 3'b000, 1'b1, 0, 0);
    for (int f = 1; f < 8; f++) run_op(64'd5, 64'd7, 3'(f), 1'b1, 0, 0);
    for (int f = 4; f < 8; f++) run_op(64'd5, 64'd7, 3'(f), 1'b0, 1, 1);
    run_op(64'd123456789, 64'd987654321, 3'b001, 1'b0, 3, 1);

    for (int n = 0; n < 300; n++) begin
      logic [63:0] ra, rb;
      logic [2:0] rf;
      logic rw;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if ($urandom % 4 == 0) ra = {{48{ra[15]}}, ra[15:0]};
      rf = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 4);
      rw = ($urandom % 4 == 0);
      if (rw && ($urandom % 2 == 0)) rf = 3'b000;
      run_op(ra, rb, rf, rw, int'($urandom % 4), bit'($urandom % 2));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule